// File: doc/BRIEF.md
# One-Time-Programmable Word Memory with Identify Mode

This block is a synthesizable model of a small one-time-programmable memory organised as 16-bit words. It is meant for the far side of a programmer controller. The controller selects a word address and drives the active-low chip-select and output-gate inputs, a flag that says programming voltage is present, and a flag that says identify mode is active. From these the memory reads, writes, verifies and identifies itself. The bidirectional data bus is modelled as a separate write-data input, a read-data output and a registered drive flag. When the drive flag is low, the data bus counts as high-impedance.

The storage starts erased, with every bit at one. A write can only pull bits to zero. The stored word becomes the old word ANDed with the write data. When chip select is high during programming, that device is inhibited, so several parts can share data and address lines. In identify mode the output carries one of two fixed 16-bit codes, chosen by address bit 0. Each code has odd parity, with the top bit used as the parity bit. The array depth is a parameter.

Top module: `otp_word_mem`

## Requirements
- R1: After reset, `dout_en` is 0 and every word of the array reads 16'hFFFF.
- R2: When `ce_n`=0 and `oe_n`=0 and `id_en`=0 at a rising edge, then after that edge `dout_en`=1 and `dout` holds the array word at `addr`.
- R3: When `ce_n` or `oe_n` is 1 at a rising edge, then after that edge `dout_en`=0 and `dout`=16'h0000 (the bus is high-impedance).
- R4: When `prog_en`=1, `oe_n`=1 and `ce_n`=0 at a rising edge, the word at `addr` becomes its old value ANDed with `din`, all 16 bits at once.
- R5: No array bit ever goes from 0 back to 1 until the next reset.
- R6: When `prog_en`=1 and `ce_n`=1 (inhibit), or when `prog_en`=0, the array does not change.
- R7: A read with `prog_en` still at 1 (verify) returns the stored word, exactly like R2.
- R8: In identify mode (`id_en`=1, `ce_n`=0, `oe_n`=0) with all address bits above bit 0 at zero, the output is 16'h00C2 (manufacturer code) when `addr[0]`=0 and 16'h80FA (device code) when `addr[0]`=1.
- R9: Both identifier codes have odd parity across all 16 bits. Bit 15 is the parity bit over the low 15 bits (low bits 15'h00C2 and 15'h00FA).
- R10: In identify mode with any address bit above bit 0 set, the output is 16'hFFFF.
- R11: A write cycle pattern with `oe_n`=0 (`prog_en`=1, `ce_n`=0) performs a verify read and does not change the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| addr | input | AW | Word address |
| din | input | 16 | Write data |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| prog_en | input | 1 | Programming voltage present |
| id_en | input | 1 | Identify mode select |
| dout | output | 16 | Registered read data |
| dout_en | output | 1 | Registered bus drive flag; 0 means high-impedance |

## Verification
Two functions can meet in one cycle. A program pulse can be applied while the identify flag is held high. The array must still take the AND-merged word, and the outputs must stay released. A program can also be followed, on the very next edge, by a verify read of the same word, which must already show the merged value. The random stimulus mixes all four control flags on every cycle, so both pairings occur many times. Every cycle is judged against a shadow array in the bench that applies the merge rule and the identify code table independently.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W = 16;

  // Build an identifier word: bit 15 makes the total count of ones odd.
  function automatic logic [WORD_W-1:0] with_odd_parity(input logic [WORD_W-2:0] low);
    return {~^low, low};
  endfunction

  // One-time-programmable merge: bits can only be cleared.
  function automatic logic [WORD_W-1:0] prog_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode (
  input  logic ce_n,
  input  logic oe_n,
  input  logic prog_en,
  output logic rd_req,
  output logic wr_req,
  output logic inhibit
);
  assign rd_req  = !ce_n && !oe_n;
  assign wr_req  = prog_en && !ce_n && oe_n;
  assign inhibit = prog_en && ce_n;

  // R4
  always_comb begin
    mode_exclusive_chk: assert ($onehot0({rd_req, wr_req, inhibit}));
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  rd_word
);
  import otp_pkg::*;

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic                    addr_ok;

  assign addr_ok = (int'(addr) < DEPTH);
  assign rd_word = addr_ok ? mem_q[addr] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '1;
    end else if (wr_req && addr_ok) begin
      mem_q[addr] <= prog_merge(mem_q[addr], din);
    end
  end

  // R5
  no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mem_q & ~$past(mem_q)) == '0));

  // R6
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(mem_q));
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
  parameter int          AW      = 6,
  parameter logic [14:0] MFR_LOW = 15'h00C2,
  parameter logic [14:0] DEV_LOW = 15'h00FA
) (
  input  logic [AW-1:0] addr,
  output logic [15:0]   id_word
);
  import otp_pkg::*;

  logic upper_clear;
  assign upper_clear = (addr[AW-1:1] == '0);

  always_comb begin
    if (!upper_clear)  id_word = '1;
    else if (addr[0])  id_word = with_odd_parity(DEV_LOW);
    else               id_word = with_odd_parity(MFR_LOW);
  end

  // R9
  always_comb begin
    if (upper_clear) id_parity_chk: assert ($countones(id_word) % 2 == 1);
  end
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   din,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          prog_en,
  input  logic          id_en,
  output logic [15:0]   dout,
  output logic          dout_en
);
  logic        rd_req, wr_req, inhibit;
  logic [15:0] arr_word, id_word, sel_word;

  otp_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .prog_en(prog_en),
    .rd_req(rd_req), .wr_req(wr_req), .inhibit(inhibit)
  );

  otp_array #(.DEPTH(DEPTH), .W(16), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req),
    .addr(addr), .din(din), .rd_word(arr_word)
  );

  otp_id_rom #(.AW(AW)) u_id (.addr(addr), .id_word(id_word));

  assign sel_word = id_en ? id_word : arr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_req;
      dout    <= rd_req ? sel_word : '0;
    end
  end

  // R3
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  // R2
  dout_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!ce_n && !oe_n));

  // R6
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !dout_en);
endmodule

// File: tb/otp_word_mem_test.sv
module otp_word_mem_test;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, prog_en = 1'b0, id_en = 1'b0;
  logic [15:0]   dout;
  logic          dout_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] shadow [DEPTH];

  always #5 clk = ~clk;

  otp_word_mem #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .prog_en(prog_en), .id_en(id_en), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [15:0] id_code(input logic [AW-1:0] a);
    logic [14:0] low;
    if (a >> 1 != 0) return 16'hFFFF;
    low = a[0] ? 15'h00FA : 15'h00C2;
    return {($countones(low) % 2 == 0), low};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp,
                       input logic got_en, input logic exp_en);
    n_cmp++;
    if (got !== exp || got_en !== exp_en) begin
      n_bad++;
      $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", req, got, got_en, exp, exp_en);
    end
  endtask

  // One cycle: drive at negedge, edge, check at following negedge.
  task automatic cycle(input string req, input logic c, input logic o, input logic p,
                       input logic i, input logic [AW-1:0] a, input logic [15:0] d);
    logic        ren;
    logic [15:0] exp;
    ce_n = c; oe_n = o; prog_en = p; id_en = i; addr = a; din = d;
    ren = !c && !o;
    exp = ren ? (i ? id_code(a) : shadow[a]) : 16'h0000;
    if (p && o && !c) shadow[a] = shadow[a] & d;
    @(negedge clk);
    check(req, dout, exp, dout_en, ren);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < DEPTH; k++) shadow[k] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1 reset", dout, 16'h0000, dout_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: erased array reads all ones
    for (int k = 0; k < DEPTH; k++) cycle("R1 erased", 0, 0, 0, 0, AW'(k), 16'h0);
    // R3: idle releases the bus
    cycle("R3 idle", 1, 1, 0, 0, 6'd3, 16'h0);
    cycle("R3 oe high", 0, 1, 0, 0, 6'd3, 16'h0);
    // R4 then R7: program then verify with prog held
    cycle("R4 program", 0, 1, 1, 0, 6'd5, 16'hA5F0);
    cycle("R7 verify", 0, 0, 1, 0, 6'd5, 16'h0);
    // R5: attempt to restore ones
    cycle("R5 reprogram", 0, 1, 1, 0, 6'd5, 16'hFFFF);
    cycle("R5 readback", 0, 0, 0, 0, 6'd5, 16'h0);
    // R6: inhibit and no-prog writes
    cycle("R6 inhibit", 1, 1, 1, 0, 6'd9, 16'h0000);
    cycle("R6 noprog", 0, 1, 0, 0, 6'd9, 16'h0000);
    cycle("R6 readback", 0, 0, 0, 0, 6'd9, 16'h0);
    // R11: oe low with prog is a verify, not a write
    cycle("R11 oe low", 0, 0, 1, 0, 6'd12, 16'h0000);
    cycle("R11 readback", 0, 0, 0, 0, 6'd12, 16'h0);
    // R8, R9, R10: identify
    cycle("R8 mfr code", 0, 0, 0, 1, 6'd0, 16'h0);
    cycle("R8 dev code", 0, 0, 0, 1, 6'd1, 16'h0);
    cycle("R9 parity mfr", 0, 0, 1, 1, 6'd0, 16'h0);
    cycle("R10 upper bit", 0, 0, 0, 1, 6'd2, 16'h0);
    cycle("R10 top bit", 0, 0, 0, 1, 6'd33, 16'h0);
    // program while identify flag high, then verify same word
    cycle("R4 prog in id", 0, 1, 1, 1, 6'd20, 16'h3C3C);
    cycle("R4 verify", 0, 0, 1, 0, 6'd20, 16'h0);
    n_cmp++;
    if (id_code(6'd0) != 16'h00C2 || $countones(id_code(6'd1)) % 2 != 1) begin
      n_bad++;
      $display("FAIL R9: bench code table %h %h expected 00c2 odd-parity", id_code(0), id_code(1));
    end
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] d;
      d = 16'($urandom | $urandom | $urandom);
      cycle("R2 random", ($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
            ($urandom % 5) == 0, AW'($urandom), d);
    end
    for (int k = 0; k < DEPTH; k++) cycle("R2 final sweep", 0, 0, 0, 0, AW'(k), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule